// File: doc/BRIEF.md
# I2C Slave Status and Address Match Unit

This unit observes an I2C bus and keeps the byte-wide status word that a slave controller's software polls. The raw clock and data lines pass through a synchronizer. The unit then detects START and STOP conditions and collects the first byte after every START or repeated START. It compares the 7-bit address in that byte against several selectable sources: a primary address, a second address, the general call address, the SMBus alert response address, and an address window.

The byte shift engine, acknowledge driving and arbitration logic are not part of this unit. They report to it through one-cycle strobes: a byte-complete strobe with the received acknowledge level, and an arbitration-loss strobe. Software reaches the unit through single-cycle strobes:

- a data-register read or write, which acknowledges a transfer;
- a control-register write, which drops the slave-selected state;
- a status write, which clears the write-1-to-clear flags.

Top module: `i2cs_status_unit`

## Requirements
- R1: After reset the status word reads 8'h80. Its bits, MSB first, are: transfer complete [7], addressed [6], bus busy [5], arbitration lost [4], range hit [3], slave read [2], interrupt pending [1], received NACK [0].
- R2: Transfer complete [7] sets on a byte-complete strobe. It clears on a data read while `tx_mode` is 0, or on a data write while `tx_mode` is 1. A data access in the other mode leaves it unchanged.
- R3: When the 7-bit address in the first byte after a START equals `own_addr`, addressed [6] becomes 1 after the eighth SCL rising edge and before the ninth (acknowledge) clock. Slave read [2] takes the byte's least significant bit.
- R4: Bus busy [5] becomes 1 after any START (SDA falling while SCL is high). It becomes 0 after any STOP (SDA rising while SCL is high).
- R5: Three address sources each match only while their enable is 1: `alt_addr` with `alt_en`, address 7'h00 with `gcall_en`, and address 7'h0C with `alert_en`.
- R6: When `range_en` is 1 and `range_addr` is nonzero, two kinds of address also match: `range_addr` itself, and any address strictly between `own_addr` and `range_addr`. Such a match also sets range hit [3]. With `range_addr` zero, the range comparison never matches.
- R7: A control-register write clears addressed [6] and range hit [3].
- R8: Arbitration lost [4] sets on an arbitration-loss strobe. Interrupt pending [1] sets on a byte-complete strobe, an arbitration-loss strobe, or an address match. Each of these two bits clears only on a status write with a 1 in its own bit position. Writing 0 there, or writing any other bit, has no effect on it.
- R9: Received NACK [0] takes `byte_nack` on each byte-complete strobe and holds it otherwise.
- R10: When a hardware set and a software clear of the same flag arrive in the same cycle, the flag ends up 1.
- R11: A non-matching address leaves addressed [6] at 0. Bytes after the first byte of a transfer are never decoded as addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw I2C clock line |
| sda_in | input | 1 | Raw I2C data line |
| own_addr | input | AW | Primary slave address |
| alt_addr | input | AW | Second slave address |
| range_addr | input | AW | Address window bound |
| alt_en | input | 1 | Enable second address match |
| gcall_en | input | 1 | Enable general call match |
| alert_en | input | 1 | Enable alert response match |
| range_en | input | 1 | Enable window match |
| tx_mode | input | 1 | 1 = transmit mode, 0 = receive mode |
| byte_done | input | 1 | Byte transfer complete strobe |
| byte_nack | input | 1 | Acknowledge level received with the byte |
| arb_lost | input | 1 | Arbitration loss strobe |
| dreg_rd | input | 1 | Data register read strobe |
| dreg_wr | input | 1 | Data register write strobe |
| ctrl_wr | input | 1 | Control register write strobe |
| stat_wr | input | 1 | Status register write strobe |
| wdata | input | 8 | Write data for the status write |
| status | output | 8 | Status word |

## Verification
Several flags can receive a hardware set and a software clear in the same cycle. The two main cases are an arbitration-loss strobe arriving with a status write that clears that bit, and a byte-complete strobe arriving with a receive-mode data read. The bench drives both strobes on the same clock edge. It then judges whether the flag is still 1 in the following cycle. A companion case drives a status write with a 0 in the arbitration bit and confirms that the bit holds its value.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int ADDR_W = 7;

    // Status bit positions (order is part of the software view)
    localparam int ST_XFER_DONE = 7;
    localparam int ST_ADDRESSED = 6;
    localparam int ST_BUSY      = 5;
    localparam int ST_ARB_LOST  = 4;
    localparam int ST_RANGE_HIT = 3;
    localparam int ST_SLV_READ  = 2;
    localparam int ST_INT_PEND  = 1;
    localparam int ST_NACK      = 0;

    localparam logic [7:0] ST_RESET_VAL = 8'h80;
    localparam logic [7:0] ST_W1C_MASK  = 8'h12;

    localparam logic [ADDR_W-1:0] GCALL_ADDR = 7'h00;
    localparam logic [ADDR_W-1:0] ALERT_ADDR = 7'h0C;

    typedef struct packed {
        logic [7:0] st;
    } flag_state_t;

endpackage

// File: rtl/i2cs_bus_monitor.sv
module i2cs_bus_monitor #(
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic start_p,
    output logic stop_p,
    output logic scl_rise,
    output logic sda_sync
);
    localparam int PIPE_W = SYNC_DEPTH + 1;

    typedef struct packed {
        logic [PIPE_W-1:0] scl;
        logic [PIPE_W-1:0] sda;
    } mon_state_t;

    mon_state_t mon_d, mon_q;

    logic scl_now, scl_old, sda_now, sda_old;

    always_comb begin
        mon_d     = mon_q;
        mon_d.scl = {mon_q.scl[PIPE_W-2:0], scl_raw};
        mon_d.sda = {mon_q.sda[PIPE_W-2:0], sda_raw};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q <= '1;
        end else begin
            mon_q <= mon_d;
        end
    end

    assign scl_now  = mon_q.scl[SYNC_DEPTH-1];
    assign scl_old  = mon_q.scl[SYNC_DEPTH];
    assign sda_now  = mon_q.sda[SYNC_DEPTH-1];
    assign sda_old  = mon_q.sda[SYNC_DEPTH];

    assign start_p  = scl_now & scl_old & sda_old & ~sda_now;
    assign stop_p   = scl_now & scl_old & ~sda_old & sda_now;
    assign scl_rise = scl_now & ~scl_old;
    assign sda_sync = sda_now;

endmodule

// File: rtl/i2cs_addr_match.sv
module i2cs_addr_match
    import i2cs_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_start,
    input  logic          bus_stop,
    input  logic          scl_rise,
    input  logic          sda,
    input  logic [AW-1:0] own_addr,
    input  logic [AW-1:0] alt_addr,
    input  logic [AW-1:0] range_addr,
    input  logic          alt_en,
    input  logic          gcall_en,
    input  logic          alert_en,
    input  logic          range_en,
    output logic          addr_hit,
    output logic          range_hit,
    output logic          slv_read
);
    localparam int CNT_W = $clog2(AW + 1);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
        logic [AW-1:0]    shift;
    } am_state_t;

    am_state_t am_d, am_q;

    logic [AW:0]   byte_w;
    logic [AW-1:0] addr_w, lo_w, hi_w;
    logic          last_bit;
    logic          hit_own, hit_alt, hit_gc, hit_alert, hit_rng;

    always_comb begin
        byte_w    = {am_q.shift, sda};
        addr_w    = byte_w[AW:1];
        last_bit  = am_q.armed & scl_rise & (am_q.cnt == CNT_W'(AW));

        lo_w      = (own_addr < range_addr) ? own_addr : range_addr;
        hi_w      = (own_addr < range_addr) ? range_addr : own_addr;

        hit_own   = (addr_w == own_addr);
        hit_alt   = alt_en & (addr_w == alt_addr);
        hit_gc    = gcall_en & (addr_w == AW'(GCALL_ADDR));
        hit_alert = alert_en & (addr_w == AW'(ALERT_ADDR));
        hit_rng   = range_en & (|range_addr) &
                    ((addr_w == range_addr) | ((addr_w > lo_w) & (addr_w < hi_w)));

        am_d = am_q;
        if (bus_start) begin
            am_d.armed = 1'b1;
            am_d.cnt   = '0;
        end else if (bus_stop) begin
            am_d.armed = 1'b0;
        end else if (am_q.armed && scl_rise) begin
            am_d.shift = {am_q.shift[AW-2:0], sda};
            am_d.cnt   = am_q.cnt + 1'b1;
            if (last_bit) begin
                am_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            am_q <= '0;
        end else begin
            am_q <= am_d;
        end
    end

    assign addr_hit  = last_bit & (hit_own | hit_alt | hit_gc | hit_alert | hit_rng);
    assign range_hit = last_bit & hit_rng;
    assign slv_read  = byte_w[0];

endmodule

// File: rtl/i2cs_flag_reg.sv
module i2cs_flag_reg
    import i2cs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_start,
    input  logic       bus_stop,
    input  logic       addr_hit,
    input  logic       range_hit,
    input  logic       slv_read,
    input  logic       byte_done,
    input  logic       byte_nack,
    input  logic       arb_lost,
    input  logic       tx_mode,
    input  logic       dreg_rd,
    input  logic       dreg_wr,
    input  logic       ctrl_wr,
    input  logic       stat_wr,
    input  logic [7:0] wdata,
    output logic [7:0] status
);
    flag_state_t fl_d, fl_q;
    logic [7:0]  set_v, clr_v;

    always_comb begin
        set_v = '0;
        set_v[ST_XFER_DONE] = byte_done;
        set_v[ST_ADDRESSED] = addr_hit;
        set_v[ST_RANGE_HIT] = addr_hit & range_hit;
        set_v[ST_BUSY]      = bus_start;
        set_v[ST_ARB_LOST]  = arb_lost;
        set_v[ST_INT_PEND]  = byte_done | arb_lost | addr_hit;

        clr_v = stat_wr ? (wdata & ST_W1C_MASK) : 8'h00;
        clr_v[ST_XFER_DONE] = tx_mode ? dreg_wr : dreg_rd;
        clr_v[ST_BUSY]      = bus_stop;
        if (ctrl_wr) begin
            clr_v[ST_ADDRESSED] = 1'b1;
            clr_v[ST_RANGE_HIT] = 1'b1;
        end

        fl_d    = fl_q;
        fl_d.st = (fl_q.st & ~clr_v) | set_v;   // set dominates
        if (addr_hit) begin
            fl_d.st[ST_SLV_READ] = slv_read;
        end
        if (byte_done) begin
            fl_d.st[ST_NACK] = byte_nack;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q.st <= ST_RESET_VAL;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign status = fl_q.st;

endmodule

// File: rtl/i2cs_status_unit.sv
module i2cs_status_unit
    import i2cs_pkg::*;
#(
    parameter int AW         = ADDR_W,
    parameter int SYNC_DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_in,
    input  logic          sda_in,
    input  logic [AW-1:0] own_addr,
    input  logic [AW-1:0] alt_addr,
    input  logic [AW-1:0] range_addr,
    input  logic          alt_en,
    input  logic          gcall_en,
    input  logic          alert_en,
    input  logic          range_en,
    input  logic          tx_mode,
    input  logic          byte_done,
    input  logic          byte_nack,
    input  logic          arb_lost,
    input  logic          dreg_rd,
    input  logic          dreg_wr,
    input  logic          ctrl_wr,
    input  logic          stat_wr,
    input  logic [7:0]    wdata,
    output logic [7:0]    status
);
    logic bus_start, bus_stop, scl_rise, sda_s;
    logic hit_pulse, rng_pulse, rw_bit;

    i2cs_bus_monitor #(.SYNC_DEPTH(SYNC_DEPTH)) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_raw  (scl_in),
        .sda_raw  (sda_in),
        .start_p  (bus_start),
        .stop_p   (bus_stop),
        .scl_rise (scl_rise),
        .sda_sync (sda_s)
    );

    i2cs_addr_match #(.AW(AW)) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_start  (bus_start),
        .bus_stop   (bus_stop),
        .scl_rise   (scl_rise),
        .sda        (sda_s),
        .own_addr   (own_addr),
        .alt_addr   (alt_addr),
        .range_addr (range_addr),
        .alt_en     (alt_en),
        .gcall_en   (gcall_en),
        .alert_en   (alert_en),
        .range_en   (range_en),
        .addr_hit   (hit_pulse),
        .range_hit  (rng_pulse),
        .slv_read   (rw_bit)
    );

    i2cs_flag_reg u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .addr_hit  (hit_pulse),
        .range_hit (rng_pulse),
        .slv_read  (rw_bit),
        .byte_done (byte_done),
        .byte_nack (byte_nack),
        .arb_lost  (arb_lost),
        .tx_mode   (tx_mode),
        .dreg_rd   (dreg_rd),
        .dreg_wr   (dreg_wr),
        .ctrl_wr   (ctrl_wr),
        .stat_wr   (stat_wr),
        .wdata     (wdata),
        .status    (status)
    );

endmodule

// File: rtl/i2cs_status_checker.sv
module i2cs_status_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_start,
    input logic       bus_stop,
    input logic       hit_pulse,
    input logic       byte_done,
    input logic       arb_lost,
    input logic       ctrl_wr,
    input logic       stat_wr,
    input logic [7:0] wdata,
    input logic [7:0] status
);
    a_r4_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> status[5]);

    a_r4_idle_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> !status[5]);

    a_r2_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> status[7]);

    a_r3_hit_flags: assert property (@(posedge clk) disable iff (!rst_n)
        hit_pulse |=> (status[6] && status[1]));

    a_r7_ctrl_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !hit_pulse) |=> (!status[6] && !status[3]));

    a_r6_range_with_addr: assert property (@(posedge clk) disable iff (!rst_n)
        status[3] |-> status[6]);

    a_r8_arb_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (status[4] && !(stat_wr && wdata[4])) |=> status[4]);

    a_r10_arb_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost && stat_wr && wdata[4]) |=> status[4]);

endmodule

bind i2cs_status_unit i2cs_status_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .hit_pulse (hit_pulse),
    .byte_done (byte_done),
    .arb_lost  (arb_lost),
    .ctrl_wr   (ctrl_wr),
    .stat_wr   (stat_wr),
    .wdata     (wdata),
    .status    (status)
);

// File: tb/i2cs_status_unit_tb_top.sv
module i2cs_status_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int WD_CYCLES  = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1, sda = 1'b1;
    logic [6:0] own_addr = 7'h3A, alt_addr = 7'h55, range_addr = 7'h00;
    logic       alt_en = 0, gcall_en = 0, alert_en = 0, range_en = 0, tx_mode = 0;
    logic       byte_done = 0, byte_nack = 0, arb_lost = 0;
    logic       dreg_rd = 0, dreg_wr = 0, ctrl_wr = 0, stat_wr = 0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] status;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2cs_status_unit dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
        .own_addr(own_addr), .alt_addr(alt_addr), .range_addr(range_addr),
        .alt_en(alt_en), .gcall_en(gcall_en), .alert_en(alert_en), .range_en(range_en),
        .tx_mode(tx_mode), .byte_done(byte_done), .byte_nack(byte_nack), .arb_lost(arb_lost),
        .dreg_rd(dreg_rd), .dreg_wr(dreg_wr), .ctrl_wr(ctrl_wr), .stat_wr(stat_wr),
        .wdata(wdata), .status(status)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] mask, input logic [7:0] exp);
        n_chk++;
        if ((status & mask) !== (exp & mask)) begin
            n_bad++;
            $display("FAIL %s: actual=%02h expected=%02h (mask %02h)", tag, status & mask, exp & mask, mask);
        end
    endtask

    // one-cycle strobe group, status sampled one cycle later
    task automatic strobe(input logic rd, input logic wr, input logic cw, input logic sw,
                          input logic [7:0] d, input logic bd, input logic nk, input logic al);
        @(negedge clk);
        dreg_rd = rd; dreg_wr = wr; ctrl_wr = cw; stat_wr = sw; wdata = d;
        byte_done = bd; byte_nack = nk; arb_lost = al;
        @(negedge clk);
        dreg_rd = 0; dreg_wr = 0; ctrl_wr = 0; stat_wr = 0; wdata = 8'h00;
        byte_done = 0; byte_nack = 0; arb_lost = 0;
    endtask

    task automatic bus_start;
        sda = 1'b1; tick(HALF);
        scl = 1'b1; tick(HALF);
        sda = 1'b0; tick(HALF);
        scl = 1'b0; tick(HALF);
    endtask

    task automatic bus_stop;
        sda = 1'b0; tick(HALF);
        scl = 1'b1; tick(HALF);
        sda = 1'b1; tick(HALF);
    endtask

    task automatic bus_bit(input logic b);
        sda = b; tick(HALF);
        scl = 1'b1; tick(HALF);
        scl = 1'b0; tick(2);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) bus_bit(b[i]);
    endtask

    // clear selection, send START + address, check, finish the transfer
    task automatic addr_try(input string tag, input logic [6:0] a, input logic rw,
                            input logic exp_hit, input logic exp_rng);
        strobe(0, 0, 1, 0, 8'h00, 0, 0, 0);
        bus_start;
        send_byte({a, rw});
        chk(tag, 8'h48, {1'b0, exp_hit, 2'b00, exp_rng, 3'b000});
        if (exp_hit) chk(tag, 8'h04, {5'b0, rw, 2'b0});
        bus_bit(1'b1);
        bus_stop;
    endtask

    task automatic t_reset;
        chk("R1 reset value", 8'hFF, 8'h80);
    endtask

    task automatic t_xfer_flag;
        tx_mode = 1;
        strobe(1, 0, 0, 0, 8'h00, 0, 0, 0);
        chk("R2 read in tx mode ignored", 8'h80, 8'h80);
        tx_mode = 0;
        strobe(1, 0, 0, 0, 8'h00, 0, 0, 0);
        chk("R2 read in rx mode clears", 8'h80, 8'h00);
        strobe(0, 0, 0, 0, 8'h00, 1, 1, 0);
        chk("R2 R9 byte done nack", 8'h83, 8'h83);
        strobe(0, 1, 0, 0, 8'h00, 0, 0, 0);
        chk("R2 write in rx mode ignored", 8'h80, 8'h80);
        tx_mode = 1;
        strobe(0, 1, 0, 0, 8'h00, 0, 0, 0);
        chk("R2 write in tx mode clears", 8'h80, 8'h00);
        strobe(0, 0, 0, 1, 8'h00, 0, 0, 0);
        chk("R8 int pend write 0 holds", 8'h02, 8'h02);
        strobe(0, 0, 0, 1, 8'h02, 0, 0, 0);
        chk("R8 int pend w1c", 8'h02, 8'h00);
        strobe(0, 0, 0, 0, 8'h00, 1, 0, 0);
        chk("R9 nack latched 0", 8'h81, 8'h80);
        tx_mode = 0;
        strobe(1, 0, 0, 0, 8'h00, 0, 0, 0);
        strobe(1, 0, 0, 0, 8'h00, 1, 0, 0);
        chk("R10 done wins over read", 8'h80, 8'h80);
        strobe(0, 0, 0, 1, 8'h02, 0, 0, 0);
    endtask

    task automatic t_arb;
        strobe(0, 0, 0, 0, 8'h00, 0, 0, 1);
        chk("R8 arb lost sets", 8'h12, 8'h12);
        strobe(0, 0, 0, 1, 8'hEF, 0, 0, 0);
        chk("R8 arb holds on other bits", 8'h12, 8'h10);
        strobe(0, 0, 0, 1, 8'h10, 0, 0, 0);
        chk("R8 arb w1c", 8'h10, 8'h00);
        strobe(0, 0, 0, 1, 8'h10, 0, 0, 1);
        chk("R10 arb set wins", 8'h10, 8'h10);
        strobe(0, 0, 0, 1, 8'h12, 0, 0, 0);
        chk("R8 arb and int cleared", 8'h12, 8'h00);
    endtask

    task automatic t_primary;
        own_addr = 7'h3A;
        bus_start;
        chk("R4 busy after start", 8'h20, 8'h20);
        send_byte({7'h3A, 1'b1});
        chk("R3 own match before ack", 8'h6E, 8'h66);
        bus_bit(1'b1);
        strobe(0, 0, 1, 0, 8'h00, 0, 0, 0);
        chk("R7 ctrl write clears addressed", 8'h44, 8'h04);
        gcall_en = 1;
        send_byte(8'h00);
        chk("R11 data byte not decoded", 8'h40, 8'h00);
        bus_bit(1'b1);
        gcall_en = 0;
        bus_stop;
        chk("R4 idle after stop", 8'h20, 8'h00);
        strobe(0, 0, 0, 1, 8'h02, 0, 0, 0);
    endtask

    task automatic t_sources;
        addr_try("R11 no match", 7'h11, 1'b0, 0, 0);
        addr_try("R3 own write", 7'h3A, 1'b0, 1, 0);
        addr_try("R5 alt disabled", 7'h55, 1'b0, 0, 0);
        alt_en = 1;
        addr_try("R5 alt enabled", 7'h55, 1'b1, 1, 0);
        alt_en = 0;
        addr_try("R5 gcall disabled", 7'h00, 1'b0, 0, 0);
        gcall_en = 1;
        addr_try("R5 gcall enabled", 7'h00, 1'b0, 1, 0);
        gcall_en = 0;
        addr_try("R5 alert disabled", 7'h0C, 1'b1, 0, 0);
        alert_en = 1;
        addr_try("R5 alert enabled", 7'h0C, 1'b1, 1, 0);
        alert_en = 0;
    endtask

    task automatic t_range;
        own_addr = 7'h20; range_addr = 7'h28;
        addr_try("R6 window disabled", 7'h24, 1'b0, 0, 0);
        range_en = 1;
        addr_try("R6 inside window", 7'h24, 1'b0, 1, 1);
        addr_try("R6 window bound", 7'h28, 1'b1, 1, 1);
        addr_try("R6 outside window", 7'h30, 1'b0, 0, 0);
        addr_try("R6 own not range", 7'h20, 1'b0, 1, 0);
        range_addr = 7'h00;
        addr_try("R6 zero bound", 7'h10, 1'b0, 0, 0);
        range_addr = 7'h28;
        addr_try("R6 inside again", 7'h21, 1'b0, 1, 1);
        strobe(0, 0, 1, 0, 8'h00, 0, 0, 0);
        chk("R7 ctrl write clears range hit", 8'h48, 8'h00);
        range_en = 0;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        t_reset;
        t_xfer_flag;
        t_arb;
        t_primary;
        t_sources;
        t_range;
        tick(5);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule